// File: doc/BRIEF.md
# Peripheral Serial Shift Register

This block is the byte-wide serial shifter of a peripheral adapter. It moves one byte at a time across a two-wire link: a clock line that the block drives (the "shift clock", `sclk_o`) and a data line (`sdat_o` when sending, `sdat_i` when receiving). A 3-bit mode field picks the direction and the pacing. Pacing is either a timer tick supplied from outside, with one clock half-period per tick, or the system clock, with one half-period per cycle. A further send mode recirculates the loaded byte without end, paced by the tick.

Software starts a transfer through the register port. A write starts a send and a read starts a receive. Both accesses also re-arm the bit counter, clear the completion flag and return the shift clock to its high idle level. The shift clock runs with equal high and low halves. Outgoing data changes on its falling edges and incoming data is taken on its rising edges. After the last outgoing bit the block stays in a short finish phase, so the far end still sees the final rising edge before the clock parks high. The counting modes raise `done_irq` when the eighth bit has moved. Timers, the other adapter registers and interrupt masking live outside this block.

Top module: `ser_shifter`

## Requirements
- R1: After reset, `sclk_o`=1, `sdat_o`=1, `done_irq`=0 and `rd_data`=0x00.
- R2: A write (`wr_en`=1) loads `wr_data` into the shift register, so `rd_data` shows it after that clock edge. The same edge clears `done_irq`, re-arms the count of 8 and sets `sclk_o` to 1. `wr_en` wins over `rd_en` when both are set.
- R3: Mode codes on `mode_sel` are 3'b001 receive/tick, 3'b010 receive/system clock, 3'b100 send/tick free-running, 3'b101 send/tick and 3'b110 send/system clock. Codes 3'b000, 3'b011 and 3'b111 disable the shifter. While it is disabled, `sclk_o` is 1 from the next edge on and no shift takes place.
- R4: In mode 3'b110, a write at edge k makes `sclk_o` toggle on every edge from k+1 on. It falls at k+1, k+3, … k+15, and at the falling edge numbered j (from 0) `sdat_o` takes the original bit 7−j. The register rotates left, so after eight bits it again holds the written byte.
- R5: In the counting send modes, the eighth falling edge sets `done_irq` and enters the finish phase. The next clock edge, with or without a tick, raises `sclk_o` once more, and after that `sclk_o` stays 1 with no further toggles. Whenever the shifter is idle, `sclk_o` is 1 and `done_irq` does not newly rise.
- R6: In receive modes (3'b001 and 3'b010), a read starts the transfer. On each rising edge of `sclk_o`, the register shifts left and takes the `sdat_i` level into bit 0, so the first bit received ends up at bit 7. The eighth rising edge sets `done_irq` and stops the clock high.
- R7: In the tick-paced modes (3'b001, 3'b100 and 3'b101), `sclk_o` changes during shifting only on edges where `tick`=1. The single exception is the finish edge of R5.
- R8: In mode 3'b100, the byte recirculates on `sdat_o` without end. The bit order is the one of R4 and repeats every 8 bits. `done_irq` never rises, and `sclk_o` keeps toggling on ticks.
- R9: A read (`rd_en`=1) shows the register contents on `rd_data`, clears `done_irq` and sets `sclk_o` to 1. In a send mode a read stops any transfer in progress, and in a receive mode a write does not start one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Shifter mode code (see R3) |
| tick | input | 1 | Timer-rate pacing pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Byte to load |
| rd_data | output | 8 | Current shift register contents |
| sclk_o | output | 1 | Shift clock to the link, idle high |
| sdat_o | output | 1 | Serial data out, MSB first |
| sdat_i | input | 1 | Serial data in, synchronous to `clk` |
| done_irq | output | 1 | Transfer-complete flag |

## Verification
Every result here is registered, so an access seen at edge k shows its loaded byte, cleared flag and high clock at k itself. In system-clock modes the i-th clock half follows at edge k+i: bit j appears at k+2j+1 when sending and is taken at k+2j+2 when receiving. The flag rises at k+15 when sending and at k+16 when receiving, and the finish edge comes at k+16. In tick modes each half-period lands on the edge that carries the tick, and the finish edge on the very next edge. The bench drives on falling clock edges and checks each output at the falling edge after the rising edge that is due to change it. Over the gaps between ticks it also checks that the clock has not moved.

// File: rtl/ser_shift_pkg.sv
// Shared types and mode decoding for the serial shifter.
// Assumes a 3-bit mode code; unlisted codes count as "disabled".
package ser_shift_pkg;

    typedef enum logic [2:0] {
        MODE_OFF      = 3'b000,
        MODE_IN_TMR   = 3'b001,
        MODE_IN_SYS   = 3'b010,
        MODE_RSV3     = 3'b011,
        MODE_OUT_FREE = 3'b100,
        MODE_OUT_TMR  = 3'b101,
        MODE_OUT_SYS  = 3'b110,
        MODE_RSV7     = 3'b111
    } sh_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } sh_state_e;

    // True for the three send modes.
    function automatic logic mode_is_out(input logic [2:0] m);
        return (m == MODE_OUT_FREE) || (m == MODE_OUT_TMR) || (m == MODE_OUT_SYS);
    endfunction

    // True for the two receive modes.
    function automatic logic mode_is_in(input logic [2:0] m);
        return (m == MODE_IN_TMR) || (m == MODE_IN_SYS);
    endfunction

    // True when the shifter is enabled at all.
    function automatic logic mode_on(input logic [2:0] m);
        return mode_is_out(m) || mode_is_in(m);
    endfunction

    // True when half-periods are paced by the external tick.
    function automatic logic mode_paced(input logic [2:0] m);
        return (m == MODE_IN_TMR) || (m == MODE_OUT_TMR) || (m == MODE_OUT_FREE);
    endfunction

    // True for the endless recirculating send mode.
    function automatic logic mode_free(input logic [2:0] m);
        return (m == MODE_OUT_FREE);
    endfunction

endpackage

// File: rtl/ser_shift_seq.sv
// Shift clock sequencer: owns the idle/shift/finish state and the shift
// clock level. Emits one-cycle fall/rise events that the data path and the
// bit counter act on. Assumes `final_bit` says the next shift is the last.
module ser_shift_seq
    import ser_shift_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       tick,
    input  logic       access,
    input  logic       start,
    input  logic       final_bit,
    output logic       sclk,
    output logic       fall_ev,
    output logic       rise_ev,
    output sh_state_e  state
);

    logic ev;
    logic run;

    // Purpose: decide whether this cycle carries a clock half-period.
    always_comb begin
        ev      = (state == ST_FINISH) ||
                  ((state == ST_SHIFT) && (!mode_paced(mode_sel) || tick));
        run     = ev && !access && mode_on(mode_sel);
        fall_ev = run && sclk && (state == ST_SHIFT);
        rise_ev = run && !sclk;
    end

    // Purpose: advance the state and toggle the shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sclk  <= 1'b1;
        end else if (!mode_on(mode_sel)) begin
            state <= ST_IDLE;
            sclk  <= 1'b1;
        end else if (access) begin
            sclk  <= 1'b1;
            state <= start ? ST_SHIFT : ST_IDLE;
        end else if (run) begin
            sclk <= ~sclk;
            case (state)
                ST_SHIFT: begin
                    if (fall_ev && mode_is_out(mode_sel) && !mode_free(mode_sel) && final_bit)
                        state <= ST_FINISH;
                    else if (rise_ev && mode_is_in(mode_sel) && final_bit)
                        state <= ST_IDLE;
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ser_shift_count.sv
// Bit counter and completion flag. Re-armed to DATA_W on every access,
// counts down modulo DATA_W on each shift, raises the flag on the shift
// that takes it to zero unless the free-running mode is selected.
module ser_shift_count #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic shift_en,
    input  logic free_mode,
    output logic final_bit,
    output logic done_irq
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: flag the shift that completes the byte.
    assign final_bit = (cnt == CNT_W'(1));

    // Purpose: keep the remaining-bit count and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= CNT_W'(DATA_W);
            done_irq <= 1'b0;
        end else if (access) begin
            cnt      <= CNT_W'(DATA_W);
            done_irq <= 1'b0;
        end else if (shift_en) begin
            cnt <= (cnt == '0) ? CNT_W'(DATA_W - 1) : cnt - CNT_W'(1);
            if (final_bit && !free_mode)
                done_irq <= 1'b1;
        end
    end

endmodule

// File: rtl/ser_shift_data.sv
// Shift register data path: parallel load, rotate-out MSB first, and
// shift-in at bit 0. Assumes the serial input is already synchronous.
module ser_shift_data #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_en,
    input  logic              in_en,
    input  logic              sdat_in,
    output logic [DATA_W-1:0] sr,
    output logic              sdat_out
);

    localparam int MSB = DATA_W - 1;

    // Purpose: load, rotate out or shift in the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            sdat_out <= 1'b1;
        end else if (load) begin
            sr <= load_data;
        end else if (out_en) begin
            sdat_out <= sr[MSB];
            sr       <= {sr[MSB-1:0], sr[MSB]};
        end else if (in_en) begin
            sr <= {sr[MSB-1:0], sdat_in};
        end
    end

endmodule

// File: rtl/ser_shifter.sv
// Top of the peripheral serial shifter. Decodes register accesses into
// start/abort, routes sequencer edge events to the data path and counter.
// Assumes single-cycle wr_en/rd_en strobes and a one-cycle tick pulse.
module ser_shifter
    import ser_shift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk_o,
    output logic              sdat_o,
    input  logic              sdat_i,
    output logic              done_irq
);

    logic      access;
    logic      start;
    logic      fall_ev;
    logic      rise_ev;
    logic      final_bit;
    logic      out_en;
    logic      in_en;
    sh_state_e seq_state;

    // Purpose: classify the access and the shifts it enables.
    always_comb begin
        access = wr_en || rd_en;
        start  = (wr_en && mode_is_out(mode_sel)) ||
                 (!wr_en && rd_en && mode_is_in(mode_sel));
        out_en = fall_ev && mode_is_out(mode_sel);
        in_en  = rise_ev && mode_is_in(mode_sel);
    end

    ser_shift_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .tick      (tick),
        .access    (access),
        .start     (start),
        .final_bit (final_bit),
        .sclk      (sclk_o),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .state     (seq_state)
    );

    ser_shift_count #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .access    (access),
        .shift_en  (out_en || in_en),
        .free_mode (mode_free(mode_sel)),
        .final_bit (final_bit),
        .done_irq  (done_irq)
    );

    ser_shift_data #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_en),
        .load_data (wr_data),
        .out_en    (out_en),
        .in_en     (in_en),
        .sdat_in   (sdat_i),
        .sr        (rd_data),
        .sdat_out  (sdat_o)
    );

endmodule

// File: rtl/ser_shifter_chk.sv
// Protocol checker for ser_shifter, attached by bind.
module ser_shifter_chk
    import ser_shift_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input logic       tick,
    input logic       wr_en,
    input logic       rd_en,
    input logic       sclk_o,
    input logic       done_irq,
    input sh_state_e  state
);

    AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on(mode_sel) |=> (sclk_o && state == ST_IDLE)); // R3

    AST_ACCESS_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |=> !done_irq); // R9

    AST_FREE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_OUT_FREE && !done_irq) |=> !done_irq); // R8

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_paced(mode_sel) && state == ST_SHIFT && !tick && !wr_en && !rd_en)
        |=> $stable(sclk_o)); // R7

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !done_irq) |=> !done_irq); // R5

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> sclk_o); // R5

endmodule

bind ser_shifter ser_shifter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .tick     (tick),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .sclk_o   (sclk_o),
    .done_irq (done_irq),
    .state    (seq_state)
);

// File: tb/ser_shifter_tb_top.sv
module ser_shifter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sclk_o;
    logic       sdat_o;
    logic       sdat_i = 1'b0;
    logic       done_irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ser_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tick(tick),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_i(sdat_i), .done_irq(done_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b);
        wr_data = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        chk("R1 sclk", sclk_o, 1); chk("R1 sdat", sdat_o, 1);
        chk("R1 irq", done_irq, 0); chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5: system-clock send, every byte value
        mode_sel = 3'b110;
        @(negedge clk);
        for (int b = 0; b < 256; b++) begin
            do_write(8'(b));
            chk("R2 load", rd_data, 32'(b)); chk("R2 irq clear", done_irq, 0);
            chk("R2 sclk high", sclk_o, 1);
            for (int i = 1; i <= 16; i++) begin
                @(negedge clk);
                chk("R4 sclk", sclk_o, (i % 2 == 1) ? 0 : 1);
                if (i % 2 == 1) chk("R4 bit", sdat_o, (b >> (7 - (i - 1) / 2)) & 1);
                chk("R5 irq", done_irq, (i >= 15) ? 1 : 0);
            end
            @(negedge clk);
            chk("R5 stopped", sclk_o, 1);
            chk("R4 restored", rd_data, 32'(b));
        end
        prev = 8'hFF;

        // R6: system-clock receive, every byte value
        mode_sel = 3'b010;
        for (int p = 0; p < 256; p++) begin
            do_read();
            chk("R9 read data", rd_data, 32'(prev)); chk("R9 irq clear", done_irq, 0);
            for (int i = 1; i <= 16; i++) begin
                if (i % 2 == 0) sdat_i = 1'((p >> (7 - (i / 2 - 1))) & 1);
                else            sdat_i = ~1'((p >> (7 - (i - 1) / 2)) & 1);
                @(negedge clk);
                chk("R6 sclk", sclk_o, (i % 2 == 1) ? 0 : 1);
                chk("R6 irq", done_irq, (i == 16) ? 1 : 0);
            end
            chk("R6 byte", rd_data, 32'(p));
            @(negedge clk);
            chk("R6 stopped", sclk_o, 1);
            prev = 8'(p);
        end

        // R9: write in receive mode does not start
        do_write(8'hA5);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 no start", sclk_o, 1);
        end
        chk("R9 loaded", rd_data, 32'hA5);

        // R7/R5: tick-paced send with finish edge
        mode_sel = 3'b101;
        do_write(8'h3C);
        for (int e = 1; e <= 15; e++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk("R7 sclk", sclk_o, (e % 2 == 1) ? 0 : 1);
            if (e % 2 == 1) chk("R7 bit", sdat_o, (32'h3C >> (7 - (e - 1) / 2)) & 1);
            chk("R5 irq timer", done_irq, (e == 15) ? 1 : 0);
            for (int g = 0; g < 3; g++) begin
                @(negedge clk);
                if (e < 15) chk("R7 hold", sclk_o, (e % 2 == 1) ? 0 : 1);
                else        chk("R5 finish edge", sclk_o, 1);
            end
        end
        for (int e = 0; e < 2; e++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
            chk("R5 no more toggles", sclk_o, 1);
        end
        chk("R5 irq held", done_irq, 1);

        // R9: read clears flag, in send mode does not start
        do_read();
        chk("R9 irq cleared", done_irq, 0); chk("R9 rd", rd_data, 32'h3C);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R9 read no start", sclk_o, 1);

        // R6/R7: tick-paced receive
        mode_sel = 3'b001;
        do_read();
        for (int e = 1; e <= 16; e++) begin
            sdat_i = 1'((32'h5B >> (7 - (e - 1) / 2)) & 1);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk("R7 rx sclk", sclk_o, (e % 2 == 1) ? 0 : 1);
            chk("R6 rx irq", done_irq, (e == 16) ? 1 : 0);
            sdat_i = ~sdat_i;
            @(negedge clk);
            chk("R7 rx hold", sclk_o, (e % 2 == 1) ? 0 : 1);
        end
        chk("R6 rx byte", rd_data, 32'h5B);

        // R8: free-running recirculation
        mode_sel = 3'b100;
        do_write(8'h96);
        for (int e = 1; e <= 48; e++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk("R8 sclk", sclk_o, (e % 2 == 1) ? 0 : 1);
            if (e % 2 == 1) chk("R8 bit", sdat_o, (32'h96 >> (7 - (((e - 1) / 2) % 8))) & 1);
            chk("R8 no irq", done_irq, 0);
            @(negedge clk);
        end
        chk("R8 rotated back", rd_data, 32'h96);

        // R3: disabling mid-transfer and reserved codes
        mode_sel = 3'b110;
        do_write(8'hF0);
        repeat (5) @(negedge clk);
        mode_sel = 3'b000;
        @(negedge clk);
        chk("R3 off high", sclk_o, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R3 off stays", sclk_o, 1);
        end
        mode_sel = 3'b011;
        do_write(8'h42);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R3 code 011 idle", sclk_o, 1);
        end
        chk("R3 loaded", rd_data, 32'h42); chk("R3 no irq", done_irq, 0);
        mode_sel = 3'b111;
        do_write(8'h24);
        tick = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R3 code 111 idle", sclk_o, 1);
        end
        tick = 1'b0;
        chk("R3 loaded 111", rd_data, 32'h24);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule